// File: doc/BRIEF.md
# Power Management Control/Status Register

This block holds the 16-bit power management control and status word of a device's configuration space, plus the 8-bit extension byte at the address after it. Software reaches it through a simple register port: one write strobe, three byte enables (byte 0 is bits 7:0, byte 1 is bits 15:8, byte 2 is the extension byte) and a combinational read bus. Static capability inputs, set up before use, decide the following:
- whether the optional states D1 and D2 exist;
- which power states may raise a wake event;
- whether the data selector is live;
- the data scale;
- the eight data bytes that the selector routes to a separate data output.

The register tracks the current power state and a wake-enable bit. It latches a sticky wake-status bit from an active-low downstream wake input, which passes through two synchroniser flops first. It drives an active-low upstream wake output when both status and enable are set. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `pm_ctrl_status`

## Requirements
- R1: After reset, state (bits 1:0) is 00, enable (bit 8) is 0, select (bits 12:9) is 0 and status (bit 15) is 0. Bits 14:13 show cfg_scale, and up_pme_n is 1.
- R2: A byte-0 write always accepts state codes 00 (D0) and 11 (D3).
- R3: A byte-0 write of code 01 (D1) or 10 (D2) is accepted only when cfg_d1_ok or cfg_d2_ok respectively is 1. Otherwise the state field keeps its old value.
- R4: Bits 7:2 and the extension byte (bits 23:16) always read 0, even after writes of all ones.
- R5: Bit 8 is writable and readable when cfg_pme_sup (bit n stands for state Dn) is nonzero. It reads 0 when cfg_pme_sup is 0.
- R6: Bits 12:9 are writable and read back only when cfg_data_en is 1. Otherwise they read 0.
- R7: pm_data shows byte k of cfg_data_bytes (bits 8k+7:8k) when select is k, for k from 0 to 7. It is 0 for select 8 to 15 and 0 when cfg_data_en is 0.
- R8: Bits 14:13 always equal cfg_scale, and writes do not change them.
- R9: Status is set on the third rising edge after dn_pme_n goes low, provided cfg_pme_sup has a 1 for the current state. This happens whatever the enable bit holds.
- R10: Status stays 0 while the support bit for the current state is 0. Writing 1 to bit 15 clears it, and writing 0 leaves it unchanged.
- R11: When a set condition and a write-1 clear fall in the same cycle, status stays 1.
- R12: up_pme_n is 0 exactly when status and the readable enable bit are both 1.
- R13: A write changes no field in a byte whose byte enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_d1_ok | input | 1 | D1 state implemented |
| cfg_d2_ok | input | 1 | D2 state implemented |
| cfg_pme_sup | input | 4 | Wake support per state, bit n = Dn |
| cfg_data_en | input | 1 | Data selector enabled |
| cfg_scale | input | 2 | Data scale value |
| cfg_data_bytes | input | 64 | Eight data bytes, byte k at bits 8k+7:8k |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 3 | Byte enables |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data |
| dn_pme_n | input | 1 | Downstream wake request, active low, asynchronous |
| up_pme_n | output | 1 | Upstream wake request, active low |
| pm_data | output | 8 | Selected data byte |

## Verification
The state field is driven with every code under each combination of the D1/D2 flags, which separates a missing support check from a check wired to the wrong flag. The wake path is run with the support bit set and clear, with enable on and off, and with a write-1 clear landing while the input is still low. Together these tell the sticky set, the precedence of set over clear, and the enable gating apart. The sample taken two edges after the input falls pins down the synchroniser depth. The selector walks codes 0 to 15 against distinct bytes to expose swapped or out-of-range routing.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 4;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pm_data_mux.sv
module pm_data_mux #(
  parameter int NBYTES = 8,
  parameter int SELW   = 4
) (
  input  logic                  enable,
  input  logic [SELW-1:0]       sel,
  input  logic [NBYTES*8-1:0]   bytes,
  output logic [7:0]            dout
);
  always_comb begin
    dout = '0;
    if (enable) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (sel == i[SELW-1:0]) dout = bytes[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/pm_ctrl_status.sv
module pm_ctrl_status
  import pm_pkg::*;
#(
  parameter int NBYTES      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DBW        = NBYTES * BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_d1_ok,
  input  logic            cfg_d2_ok,
  input  logic [3:0]      cfg_pme_sup,
  input  logic            cfg_data_en,
  input  logic [1:0]      cfg_scale,
  input  logic [DBW-1:0]  cfg_data_bytes,
  input  logic            reg_wr,
  input  logic [2:0]      reg_be,
  input  logic [23:0]     reg_wdata,
  output logic [23:0]     reg_rdata,
  input  logic            dn_pme_n,
  output logic            up_pme_n,
  output logic [7:0]      pm_data
);
  logic                 rst_sync_n;
  logic                 pme_sync_n;
  pstate_e              state_q, state_d;
  logic                 en_q, en_d;
  logic [SEL_W-1:0]     sel_q, sel_d;
  logic                 sts_q, sts_d;
  logic                 en_rd;
  logic [SEL_W-1:0]     sel_rd;
  logic                 wr_lo, wr_hi;
  logic                 req_ok;
  logic                 pme_set;
  pstate_e              req_state;

  // Reset: asserted asynchronously, released through two flops
  pm_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  // Downstream wake input synchroniser, idles high
  pm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pme_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(dn_pme_n), .q(pme_sync_n));

  assign wr_lo     = reg_wr & reg_be[0];
  assign wr_hi     = reg_wr & reg_be[1];
  assign req_state = pstate_e'(reg_wdata[1:0]);

  always_comb begin
    unique case (req_state)
      PS_D1:   req_ok = cfg_d1_ok;
      PS_D2:   req_ok = cfg_d2_ok;
      default: req_ok = 1'b1;
    endcase
  end

  assign pme_set = ~pme_sync_n & cfg_pme_sup[state_q];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    sel_d   = sel_q;
    sts_d   = sts_q;
    if (wr_lo && req_ok) state_d = req_state;
    if (wr_hi && (|cfg_pme_sup)) en_d = reg_wdata[8];
    if (wr_hi && cfg_data_en) sel_d = reg_wdata[12:9];
    if (wr_hi && reg_wdata[15]) sts_d = 1'b0;
    if (pme_set) sts_d = 1'b1;   // set wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PS_D0;
      en_q    <= 1'b0;
      sel_q   <= '0;
      sts_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      sel_q   <= sel_d;
      sts_q   <= sts_d;
    end
  end

  assign en_rd  = en_q & (|cfg_pme_sup);
  assign sel_rd = cfg_data_en ? sel_q : '0;

  assign reg_rdata = {8'h00, sts_q, cfg_scale, sel_rd, en_rd, 3'b000, 1'b0, 2'b00, state_q};
  assign up_pme_n  = ~(sts_q & en_rd);

  pm_data_mux #(.NBYTES(NBYTES), .SELW(SEL_W)) u_mux (
    .enable(cfg_data_en), .sel(sel_q), .bytes(cfg_data_bytes), .dout(pm_data));
endmodule

// File: rtl/pm_ctrl_status_chk.sv
module pm_ctrl_status_chk #(
  parameter int NBYTES = 8,
  localparam int DBW   = NBYTES * 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_d1_ok,
  input logic            cfg_d2_ok,
  input logic [3:0]      cfg_pme_sup,
  input logic            cfg_data_en,
  input logic [1:0]      cfg_scale,
  input logic [DBW-1:0]  cfg_data_bytes,
  input logic            reg_wr,
  input logic [2:0]      reg_be,
  input logic [23:0]     reg_wdata,
  input logic [23:0]     reg_rdata,
  input logic            dn_pme_n,
  input logic            up_pme_n,
  input logic [7:0]      pm_data
);
  a_r3_unsup_d1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[0] && reg_wdata[1:0] == 2'b01 && !cfg_d1_ok)
      |=> reg_rdata[1:0] == $past(reg_rdata[1:0]));

  a_r3_unsup_d2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[0] && reg_wdata[1:0] == 2'b10 && !cfg_d2_ok)
      |=> reg_rdata[1:0] == $past(reg_rdata[1:0]));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:2] == 6'd0 && reg_rdata[23:16] == 8'd0);

  a_r5_en_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pme_sup == 4'd0 |-> !reg_rdata[8]);

  a_r6_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_data_en |-> reg_rdata[12:9] == 4'd0);

  a_r7_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_data_en || reg_rdata[12]) |-> pm_data == 8'd0);

  a_r8_scale_follow: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[14:13] == cfg_scale);

  a_r10_write0_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[1] && !reg_wdata[15] && reg_rdata[15]) |=> reg_rdata[15]);

  a_r12_up_pme: assert property (@(posedge clk) disable iff (!rst_n)
    up_pme_n == !(reg_rdata[15] && reg_rdata[8]));
endmodule

bind pm_ctrl_status pm_ctrl_status_chk #(.NBYTES(NBYTES)) u_chk (.*);

// File: tb/pm_ctrl_status_tb.sv
module pm_ctrl_status_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_d1_ok, cfg_d2_ok, cfg_data_en;
  logic [3:0]  cfg_pme_sup;
  logic [1:0]  cfg_scale;
  logic [63:0] cfg_data_bytes;
  logic        reg_wr;
  logic [2:0]  reg_be;
  logic [23:0] reg_wdata, reg_rdata;
  logic        dn_pme_n, up_pme_n;
  logic [7:0]  pm_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  pm_ctrl_status u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] be, input logic [23:0] d);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 3'b000; reg_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset word", {8'h0, reg_rdata}, 32'h0000_4000);
    chk("R1 up_pme_n", {31'h0, up_pme_n}, 32'h1);
  endtask

  task automatic t_state;
    cfg_d1_ok = 0; cfg_d2_ok = 0;
    wr(3'b001, 24'h3);  chk("R2 D3 taken", {30'h0, reg_rdata[1:0]}, 3);
    wr(3'b001, 24'h1);  chk("R3 D1 dropped", {30'h0, reg_rdata[1:0]}, 3);
    wr(3'b001, 24'h2);  chk("R3 D2 dropped", {30'h0, reg_rdata[1:0]}, 3);
    wr(3'b001, 24'h0);  chk("R2 D0 taken", {30'h0, reg_rdata[1:0]}, 0);
    cfg_d1_ok = 1;
    wr(3'b001, 24'h1);  chk("R3 D1 taken", {30'h0, reg_rdata[1:0]}, 1);
    wr(3'b001, 24'h2);  chk("R3 D2 dropped with only D1", {30'h0, reg_rdata[1:0]}, 1);
    cfg_d2_ok = 1;
    wr(3'b001, 24'h2);  chk("R3 D2 taken", {30'h0, reg_rdata[1:0]}, 2);
    wr(3'b010, 24'h3);  chk("R13 be0 off keeps state", {30'h0, reg_rdata[1:0]}, 2);
    wr(3'b001, 24'h0);
  endtask

  task automatic t_reserved_scale;
    wr(3'b111, 24'hFF_60FC);
    chk("R4 reserved zero", {24'h0, reg_rdata[23:16], reg_rdata[7:2], 2'b0} , 0);
    chk("R8 scale held", {30'h0, reg_rdata[14:13]}, {30'h0, cfg_scale});
    cfg_scale = 2'b01; #1;
    chk("R8 scale follows preload", {30'h0, reg_rdata[14:13]}, 1);
    wr(3'b001, 24'h0);
  endtask

  task automatic t_enable;
    cfg_pme_sup = 4'b0000;
    wr(3'b010, 24'h000100);
    chk("R5 enable read-only 0", {31'h0, reg_rdata[8]}, 0);
    cfg_pme_sup = 4'b1001;
    wr(3'b010, 24'h000100);
    chk("R5 enable set", {31'h0, reg_rdata[8]}, 1);
    wr(3'b001, 24'h000000);
    chk("R13 be1 off keeps enable", {31'h0, reg_rdata[8]}, 1);
    wr(3'b010, 24'h000000);
    chk("R5 enable cleared", {31'h0, reg_rdata[8]}, 0);
  endtask

  task automatic t_data;
    cfg_data_en = 0;
    wr(3'b010, 24'h000600);
    chk("R6 select read 0 when off", {28'h0, reg_rdata[12:9]}, 0);
    chk("R7 data 0 when off", {24'h0, pm_data}, 0);
    cfg_data_en = 1;
    for (int k = 0; k < 16; k++) begin
      wr(3'b010, 24'(k << 9));
      chk($sformatf("R6 select %0d", k), {28'h0, reg_rdata[12:9]}, k);
      chk($sformatf("R7 data sel %0d", k), {24'h0, pm_data},
          (k < 8) ? {24'h0, cfg_data_bytes[k*8 +: 8]} : 32'h0);
    end
    wr(3'b010, 24'h0);
  endtask

  task automatic t_pme;
    cfg_pme_sup = 4'b0001; // D0 only
    wr(3'b001, 24'h3);     // go to D3, unsupported for wake
    dn_pme_n = 0;
    repeat (4) @(negedge clk);
    chk("R10 no set unsupported state", {31'h0, reg_rdata[15]}, 0);
    dn_pme_n = 1;
    repeat (3) @(negedge clk);
    wr(3'b001, 24'h0);     // back to D0, supported
    wr(3'b010, 24'h0);     // enable stays 0
    dn_pme_n = 0;
    repeat (2) @(negedge clk);
    chk("R9 not yet after two edges", {31'h0, reg_rdata[15]}, 0);
    @(negedge clk);
    chk("R9 set on third edge, enable 0", {31'h0, reg_rdata[15]}, 1);
    chk("R12 no upstream without enable", {31'h0, up_pme_n}, 1);
    wr(3'b010, 24'h008000); // clear while input still low
    chk("R11 set wins over clear", {31'h0, reg_rdata[15]}, 1);
    dn_pme_n = 1;
    repeat (3) @(negedge clk);
    wr(3'b010, 24'h000100); // enable, write 0 to status
    chk("R10 write 0 keeps status", {31'h0, reg_rdata[15]}, 1);
    chk("R12 upstream asserted", {31'h0, up_pme_n}, 0);
    wr(3'b010, 24'h008100);
    chk("R10 write 1 clears", {31'h0, reg_rdata[15]}, 0);
    chk("R12 upstream released", {31'h0, up_pme_n}, 1);
  endtask

  initial begin
    rst_n = 0; cfg_d1_ok = 0; cfg_d2_ok = 0; cfg_pme_sup = 0; cfg_data_en = 0;
    cfg_scale = 2'b10; cfg_data_bytes = 64'hA7_96_85_74_63_52_41_30;
    reg_wr = 0; reg_be = 0; reg_wdata = 0; dn_pme_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_state();
    t_reserved_scale();
    t_enable();
    t_data();
    t_pme();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule